// File: doc/BRIEF.md
# FEC Link Control and Status Register Bank

This block is the software-visible register bank for a backplane link sequencer that can use forward error correction (FEC). A word-addressed bus port reads and writes four consecutive words. Sideband inputs come from the sequencer and the FEC datapath, and sideband outputs go back to them. The sequencer, the FEC encoder and transcoder, and the circuits that corrupt bits all sit outside the block.

Software uses the control word for two things. It sets the FEC request level. It fires a one-cycle sequencer reset strobe, which is needed so that negotiation restarts whenever the request level changes. The status word is a read-only snapshot of the following:
- link readiness
- two sticky timeout flags
- a one-hot sequencer mode
- two FEC capability flags

The timeout flags are cleared by the sequencer, not by software. The injection word holds the error-insertion settings and a self-clearing "go" bit, which becomes a single pulse toward the transmit path. The last word is a saturating count of corrected FEC blocks. A read of that word returns the count and clears it.

Top module: `fec_csr`

## Requirements
- R1: After synchronous reset:
  - all four words read 0 while the sideband inputs are low
  - `fec_request`, `seq_reset_pulse`, `inj_pulse`, `inj_trans_en` and `inj_burst_en` are 0
  - `inj_burst_len` is 1
- R2: A read asserted in one cycle returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle. `bus_rvalid` is low in every cycle that does not follow a read.
- R3: Control word (offset 0) bit 18 is read/write and drives `fec_request`. Every other bit of the control word reads 0.
- R4: Writing a 1 to control word bit 0 raises `seq_reset_pulse` for exactly the one cycle after the write. The bit always reads 0.
- R5: Injection word (offset 2) layout, read/write:
  - bit 0 drives `inj_trans_en`
  - bit 1 drives `inj_burst_en`
  - bits 5:2 hold the burst length
  - all other bits read 0
- R6: Writing a 1 to injection word bit 11 raises `inj_pulse` for exactly the one cycle after the write. The bit reads 0, and a write with bit 11 at 0 gives no pulse.
- R7: `inj_burst_len` equals the burst length field, except that a field value of 0 drives 1.
- R8: Status word (offset 1) layout:
  - bit 0: link ready
  - bit 1: auto-negotiation timeout
  - bit 2: link-training timeout
  - bits 13:8: `seq_mode` (bit 8 AN, bit 9 link training, bit 10 10G data, bit 11 GbE data, bit 12 reserved, bit 13 10G FEC)
  - bit 16: FEC ability
  - bit 17: FEC error-indication ability
  - other bits read 0
  - writes to the status word have no effect
- R9: The auto-negotiation timeout flag sets on `seq_an_timeout` and stays set until `seq_an_restart`. When both arrive in the same cycle, the flag is set.
- R10: The link-training timeout flag sets on `seq_lt_timeout` and is held and cleared in the same way as the R9 flag, by `seq_an_restart`.
- R11: The corrected-block counter (offset 3) increments once per cycle with `fec_corr_blk` high. It holds at all ones and never wraps.
- R12: A read of offset 3 returns the count as it stood before the read and clears the counter. If an increment arrives in the same cycle as the read, the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| seq_link_ready | input | 1 | Sequencer reports the link is ready |
| seq_an_timeout | input | 1 | Auto-negotiation timeout event |
| seq_lt_timeout | input | 1 | Link-training timeout event |
| seq_an_restart | input | 1 | Sequencer restarts auto-negotiation; clears the timeout flags |
| seq_mode | input | 6 | One-hot sequencer mode |
| fec_ability | input | 1 | PHY supports FEC |
| fec_err_ability | input | 1 | PHY can report FEC decode errors |
| fec_corr_blk | input | 1 | One corrected FEC block this cycle |
| fec_request | output | 1 | FEC request level to the sequencer |
| seq_reset_pulse | output | 1 | One-cycle sequencer reset strobe |
| inj_trans_en | output | 1 | Error insertion enabled in the transcoder |
| inj_burst_en | output | 1 | Burst error insertion enabled in the encoder |
| inj_burst_len | output | 5 | Effective burst length, 1 to 15 |
| inj_pulse | output | 1 | One-cycle error-insert strobe |

## Verification
The assertions check several properties on every cycle:
- the one-cycle read latency
- each strobe is traced back to a write that carried its bit
- the driven burst length is never 0
- the timeout flag stays sticky until a restart
- the counter never wraps and never moves backwards except on a clearing read

The scoreboard scenarios are the only evidence of the exact values: field placement in each word, readback of the self-clearing bits as 0, immunity of the status word to writes, the same-cycle timeout-and-restart case, and the value returned and left behind by a read that meets an increment.

// File: rtl/fec_csr_pkg.sv
package fec_csr_pkg;

    localparam int DATA_W     = 32;
    localparam int MODE_W     = 6;
    localparam int LEN_W      = 4;
    localparam int EFF_LEN_W  = LEN_W + 1;

    // control word
    localparam int CTL_RST_BIT = 0;
    localparam int CTL_REQ_BIT = 18;
    // injection word
    localparam int INJ_TRN_BIT = 0;
    localparam int INJ_BST_BIT = 1;
    localparam int INJ_LEN_LSB = 2;
    localparam int INJ_GO_BIT  = 11;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_INJ,
        SEL_CNT,
        SEL_NONE
    } word_sel_t;

    typedef struct packed {
        logic             trans_en;
        logic             burst_en;
        logic [LEN_W-1:0] len;
    } inj_cfg_t;

    typedef struct packed {
        logic              err_ab;
        logic              fec_ab;
        logic [MODE_W-1:0] mode;
        logic              lt_to;
        logic              an_to;
        logic              link_ok;
    } seq_stat_t;

    function automatic logic [DATA_W-1:0] pack_status(input seq_stat_t s);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = s.link_ok;
        w[1]     = s.an_to;
        w[2]     = s.lt_to;
        w[13:8]  = s.mode;
        w[16]    = s.fec_ab;
        w[17]    = s.err_ab;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_inj(input inj_cfg_t c);
        logic [DATA_W-1:0] w;
        w                                  = '0;
        w[INJ_TRN_BIT]                     = c.trans_en;
        w[INJ_BST_BIT]                     = c.burst_en;
        w[INJ_LEN_LSB +: LEN_W]            = c.len;
        return w;
    endfunction

    function automatic logic [EFF_LEN_W-1:0] eff_len(input logic [LEN_W-1:0] f);
        return (f == '0) ? EFF_LEN_W'(1) : {1'b0, f};
    endfunction

endpackage

// File: rtl/fec_csr_sticky.sv
module fec_csr_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/fec_csr_satcnt.sv
module fec_csr_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (clr_i)
            count_o <= inc_i ? W'(1) : '0;
        else if (inc_i && count_o != TOP)
            count_o <= count_o + W'(1);
    end
endmodule

// File: rtl/fec_csr_strobe.sv
module fec_csr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic pulse_o
);
    always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= fire_i;
    end
endmodule

// File: rtl/fec_csr.sv
module fec_csr
    import fec_csr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hB0,
    parameter int                CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic                 seq_link_ready,
    input  logic                 seq_an_timeout,
    input  logic                 seq_lt_timeout,
    input  logic                 seq_an_restart,
    input  logic [5:0]           seq_mode,
    input  logic                 fec_ability,
    input  logic                 fec_err_ability,
    input  logic                 fec_corr_blk,
    output logic                 fec_request,
    output logic                 seq_reset_pulse,
    output logic                 inj_trans_en,
    output logic                 inj_burst_en,
    output logic [4:0]           inj_burst_len,
    output logic                 inj_pulse
);
    localparam int N_FLAGS = 2;

    word_sel_t         sel;
    logic [ADDR_W-1:0] off;
    logic              fec_req_q;
    inj_cfg_t          inj_q;
    logic              an_to_q;
    logic              lt_to_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rd_word;
    seq_stat_t         stat;
    logic              wr_ctrl, wr_inj, cnt_clr;

    always_comb begin
        off = bus_addr - BASE_ADDR;
        case (off)
            ADDR_W'(0): sel = SEL_CTRL;
            ADDR_W'(1): sel = SEL_STAT;
            ADDR_W'(2): sel = SEL_INJ;
            ADDR_W'(3): sel = SEL_CNT;
            default:    sel = SEL_NONE;
        endcase
    end

    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_inj  = bus_wr && (sel == SEL_INJ);
    assign cnt_clr = bus_rd && (sel == SEL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fec_req_q <= 1'b0;
            inj_q     <= '0;
        end else begin
            if (wr_ctrl)
                fec_req_q <= bus_wdata[CTL_REQ_BIT];
            if (wr_inj) begin
                inj_q.trans_en <= bus_wdata[INJ_TRN_BIT];
                inj_q.burst_en <= bus_wdata[INJ_BST_BIT];
                inj_q.len      <= bus_wdata[INJ_LEN_LSB +: LEN_W];
            end
        end
    end

    fec_csr_strobe rst_strobe_i (
        .clk    (clk),
        .rst    (rst),
        .fire_i (wr_ctrl && bus_wdata[CTL_RST_BIT]),
        .pulse_o(seq_reset_pulse)
    );

    fec_csr_strobe inj_strobe_i (
        .clk    (clk),
        .rst    (rst),
        .fire_i (wr_inj && bus_wdata[INJ_GO_BIT]),
        .pulse_o(inj_pulse)
    );

    // both timeout flags share one structure; generate picks the event
    logic [N_FLAGS-1:0] to_set, to_flag;
    assign to_set = {seq_lt_timeout, seq_an_timeout};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_timeout
        fec_csr_sticky flag_i (
            .clk   (clk),
            .rst   (rst),
            .set_i (to_set[g]),
            .clr_i (seq_an_restart),
            .flag_o(to_flag[g])
        );
    end

    assign an_to_q = to_flag[0];
    assign lt_to_q = to_flag[1];

    fec_csr_satcnt #(.W(CNT_W)) corr_cnt_i (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (fec_corr_blk),
        .clr_i  (cnt_clr),
        .count_o(cnt_q)
    );

    always_comb begin
        stat.link_ok = seq_link_ready;
        stat.an_to   = an_to_q;
        stat.lt_to   = lt_to_q;
        stat.mode    = seq_mode;
        stat.fec_ab  = fec_ability;
        stat.err_ab  = fec_err_ability;
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_CTRL: rd_word[CTL_REQ_BIT] = fec_req_q;
            SEL_STAT: rd_word = pack_status(stat);
            SEL_INJ:  rd_word = pack_inj(inj_q);
            SEL_CNT:  rd_word = DATA_W'(cnt_q);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd)
                bus_rdata <= rd_word;
        end
    end

    assign fec_request   = fec_req_q;
    assign inj_trans_en  = inj_q.trans_en;
    assign inj_burst_en  = inj_q.burst_en;
    assign inj_burst_len = eff_len(inj_q.len);

endmodule

// File: rtl/fec_csr_chk.sv
module fec_csr_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hB0,
    parameter int                CNT_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic              seq_reset_pulse,
    input logic              inj_pulse,
    input logic [4:0]        inj_burst_len,
    input logic              seq_an_timeout,
    input logic              seq_an_restart,
    input logic              an_to,
    input logic [CNT_W-1:0]  cnt
);
    logic clr;
    assign clr = bus_rd && (bus_addr == BASE_ADDR + ADDR_W'(3));

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);
    // R4
    seq_rst_origin_chk: assert property (@(posedge clk) disable iff (rst)
        seq_reset_pulse |-> $past(bus_wr && bus_addr == BASE_ADDR && bus_wdata[0]));
    // R6
    inj_origin_chk: assert property (@(posedge clk) disable iff (rst)
        inj_pulse |-> $past(bus_wr && bus_addr == BASE_ADDR + ADDR_W'(2) && bus_wdata[11]));
    // R7
    burst_len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        inj_burst_len != 5'd0 && inj_burst_len <= 5'd15);
    // R9
    an_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        an_to && !seq_an_restart |=> an_to);
    // R9
    an_set_chk: assert property (@(posedge clk) disable iff (rst)
        seq_an_timeout |=> an_to);
    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}}) && !clr |=> cnt == {CNT_W{1'b1}});
    // R11
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));
    // R12
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt <= CNT_W'(1));
endmodule

bind fec_csr fec_csr_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .CNT_W    (CNT_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rd         (bus_rd),
    .bus_rvalid     (bus_rvalid),
    .seq_reset_pulse(seq_reset_pulse),
    .inj_pulse      (inj_pulse),
    .inj_burst_len  (inj_burst_len),
    .seq_an_timeout (seq_an_timeout),
    .seq_an_restart (seq_an_restart),
    .an_to          (an_to_q),
    .cnt            (cnt_q)
);

// File: tb/fec_csr_tb_top.sv
module fec_csr_tb_top;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [7:0] A_CTL = 8'hB0;
    localparam logic [7:0] A_ST  = 8'hB1;
    localparam logic [7:0] A_INJ = 8'hB2;
    localparam logic [7:0] A_CNT = 8'hB3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        seq_link_ready = 0, seq_an_timeout = 0, seq_lt_timeout = 0, seq_an_restart = 0;
    logic [5:0]  seq_mode = '0;
    logic        fec_ability = 0, fec_err_ability = 0, fec_corr_blk = 0;
    logic        fec_request, seq_reset_pulse, inj_trans_en, inj_burst_en, inj_pulse;
    logic [4:0]  inj_burst_len;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    fec_csr #(.ADDR_W(ADDR_W), .BASE_ADDR(8'hB0), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .seq_link_ready(seq_link_ready), .seq_an_timeout(seq_an_timeout),
        .seq_lt_timeout(seq_lt_timeout), .seq_an_restart(seq_an_restart),
        .seq_mode(seq_mode), .fec_ability(fec_ability), .fec_err_ability(fec_err_ability),
        .fec_corr_blk(fec_corr_blk), .fec_request(fec_request),
        .seq_reset_pulse(seq_reset_pulse), .inj_trans_en(inj_trans_en),
        .inj_burst_en(inj_burst_en), .inj_burst_len(inj_burst_len), .inj_pulse(inj_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected rvalid", 32'(bus_rvalid), 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t, input bit inc = 0);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1; fec_corr_blk = inc;
        @(negedge clk);
        bus_rd = 1'b0; fec_corr_blk = 1'b0;
    endtask

    task automatic corr_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fec_corr_blk = 1'b1;
        end
        @(negedge clk); fec_corr_blk = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(fec_request == 0 && seq_reset_pulse == 0 && inj_pulse == 0, "R1 outputs", 32'(fec_request), 0);
        check(inj_trans_en == 0 && inj_burst_en == 0, "R1 enables", 32'({inj_trans_en, inj_burst_en}), 0);
        check(inj_burst_len == 5'd1, "R1 burst len", 32'(inj_burst_len), 1);
        check(bus_rvalid == 0, "R2 idle rvalid", 32'(bus_rvalid), 0);
        bus_read(A_CTL, 0, "R1 ctrl word");
        bus_read(A_ST,  0, "R1 status word");
        bus_read(A_INJ, 0, "R1 inj word");
        bus_read(A_CNT, 0, "R1 counter word");

        // R3 request bit, other bits zero
        bus_write(A_CTL, 32'hFFFF_FFFE);
        check(seq_reset_pulse == 0, "R4 no pulse when bit0 clear", 32'(seq_reset_pulse), 0);
        check(fec_request == 1, "R3 request set", 32'(fec_request), 1);
        bus_read(A_CTL, 32'h0004_0000, "R3 ctrl readback");
        bus_write(A_CTL, 32'h0000_0000);
        check(fec_request == 0, "R3 request cleared", 32'(fec_request), 0);

        // R4 reset strobe
        bus_write(A_CTL, 32'h0004_0001);
        check(seq_reset_pulse == 1, "R4 pulse", 32'(seq_reset_pulse), 1);
        @(negedge clk);
        check(seq_reset_pulse == 0, "R4 pulse one cycle", 32'(seq_reset_pulse), 0);
        bus_read(A_CTL, 32'h0004_0000, "R4 strobe bit reads 0");

        // R5 / R7 / R6 negative
        bus_write(A_INJ, 32'hFFFF_F7FF);
        check(inj_pulse == 0, "R6 no pulse with go clear", 32'(inj_pulse), 0);
        check(inj_trans_en && inj_burst_en, "R5 enables", 32'({inj_trans_en, inj_burst_en}), 3);
        check(inj_burst_len == 5'd15, "R7 len 15", 32'(inj_burst_len), 15);
        bus_read(A_INJ, 32'h0000_003F, "R5 inj readback");
        bus_write(A_INJ, 32'h0000_0008);
        check(inj_burst_len == 5'd2 && !inj_trans_en && !inj_burst_en, "R7 len 2", 32'(inj_burst_len), 2);
        bus_write(A_INJ, 32'h0000_0001);
        check(inj_burst_len == 5'd1, "R7 zero field drives 1", 32'(inj_burst_len), 1);
        check(inj_trans_en && !inj_burst_en, "R5 trans only", 32'({inj_trans_en, inj_burst_en}), 2);

        // R6 insert strobe
        bus_write(A_INJ, 32'h0000_080D);
        check(inj_pulse == 1, "R6 pulse", 32'(inj_pulse), 1);
        @(negedge clk);
        check(inj_pulse == 0, "R6 pulse one cycle", 32'(inj_pulse), 0);
        bus_read(A_INJ, 32'h0000_000D, "R6 go bit reads 0");

        // R8 status mapping
        seq_link_ready = 1; seq_mode = 6'b000100; fec_ability = 1; fec_err_ability = 0;
        bus_read(A_ST, 32'h0001_0401, "R8 status pattern A");
        seq_link_ready = 0; seq_mode = 6'b100000; fec_ability = 0; fec_err_ability = 1;
        bus_read(A_ST, 32'h0002_2000, "R8 status pattern B");
        bus_write(A_ST, 32'hFFFF_FFFF);
        bus_read(A_ST, 32'h0002_2000, "R8 status ignores write");
        seq_mode = '0; fec_err_ability = 0;

        // R9 AN timeout sticky
        @(negedge clk); seq_an_timeout = 1;
        @(negedge clk); seq_an_timeout = 0;
        repeat (3) @(negedge clk);
        bus_read(A_ST, 32'h0000_0002, "R9 flag set and held");
        @(negedge clk); seq_an_restart = 1;
        @(negedge clk); seq_an_restart = 0;
        bus_read(A_ST, 32'h0000_0000, "R9 cleared by restart");
        @(negedge clk); seq_an_restart = 1; seq_an_timeout = 1;
        @(negedge clk); seq_an_restart = 0; seq_an_timeout = 0;
        bus_read(A_ST, 32'h0000_0002, "R9 set wins over restart");

        // R10 LT timeout sticky
        @(negedge clk); seq_lt_timeout = 1; seq_an_restart = 1;
        @(negedge clk); seq_lt_timeout = 0; seq_an_restart = 0;
        bus_read(A_ST, 32'h0000_0004, "R10 lt set, an cleared");
        bus_read(A_ST, 32'h0000_0004, "R10 lt held");
        @(negedge clk); seq_an_restart = 1;
        @(negedge clk); seq_an_restart = 0;
        bus_read(A_ST, 32'h0000_0000, "R10 lt cleared by restart");

        // R11 / R12 counter
        corr_pulses(5);
        bus_read(A_CNT, 32'd5, "R11 count 5");
        bus_read(A_CNT, 32'd0, "R12 cleared after read");
        corr_pulses(20);
        bus_read(A_CNT, 32'd15, "R11 saturated");
        bus_read(A_CNT, 32'd0, "R12 clear from saturation");
        corr_pulses(3);
        bus_read(A_CNT, 32'd3, "R12 read with increment returns old", 1'b1);
        bus_read(A_CNT, 32'd1, "R12 restarts at 1");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all reads returned", 32'(exp_q.size()), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule